// File: doc/BRIEF.md
# Vectored Interrupt Controller with Selectable Sensing

The block gathers a set of active-low interrupt request lines. Even-numbered lines are external pins. Odd-numbered lines come from internal sources. The block merges them into one request to the processor core. Three registers control it: a mask register, a pending register and a sense register. A fourth, read-only register holds the vector. All four are reached through a plain 32-bit port with word address, write enable, write data and combinational read data. Register bits are numbered from the top, so source n lives at bit 31 − n.

Every line first passes through a two-flop synchronizer. A level-sensed source shows up in the pending register for as long as its line is low, and software cannot clear it. An even source whose sense bit is set becomes edge-sensed instead. In that mode a falling edge latches its pending bit, and the bit stays set until software writes a 1 to it. The vector register reports the lowest-numbered source that is pending and enabled. It returns the code 15 when no such source exists. The request output is the registered OR of all pending, enabled sources.

Top module: `sense_vic`

## Requirements
- R1: Source n (0..14) maps to bit 31−n of the pending, mask and sense registers. Bits 16:0 of these registers always read 0, so writing all ones to the mask reads back 0xFFFE0000.
- R2: After reset, mask, pending and sense all read 0. The vector reads 0x3C000000 (code 15) and irq_o is 0.
- R3: A mask bit of 1 enables its source. A pending source whose mask bit is 0 still reads as pending, but it does not assert irq_o and it does not appear in the vector.
- R4: With its sense bit at 0, a source is level sensed. Its pending bit is set while the pin is low, visible three cycles after the pin changes. Writing 1 to that pending bit has no effect.
- R5: With its sense bit at 1, an even source latches pending on a falling edge of its pin and holds it after the pin returns high. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R6: Sense bits of odd sources are ignored. They read back 0, and the odd source stays level sensed.
- R7: A falling edge that lands in the same cycle as a write-1 clear of the same edge-sensed bit wins, and the pending bit stays set.
- R8: Priority is fixed: the lowest-numbered source that is both pending and enabled is selected.
- R9: The vector register returns the selected source number in bits 31:26 and 0 in bits 25:0. It returns code 15 when nothing is selected.
- R10: irq_o equals, one cycle later, the OR of all pending-and-enabled sources.
- R11: Address 0 selects pending (write 1 to clear), address 1 selects mask, address 2 selects sense and address 3 selects the read-only vector. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 15 | Request lines, active low, index = source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Combined interrupt request to the core |

## Verification
Four properties are checked on every cycle: level-sensed pending bits track the synchronized lines, edge-sensed bits hold or clear as the write-1 rule says, an edge beats a simultaneous clear, and irq_o lags the pending-and-enabled OR by exactly one cycle. The same holds for the rule that the vector always names the lowest active source, or code 15 when none is active. The directed scenarios cover the rest. Those are the bit-reversed register layout, the masking of odd sense bits, the ignored writes to the vector, and the precisely timed collision between an edge and a clear. Only the scenarios show these at the register port.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    ADR_PEND  = 2'd0,
    ADR_MASK  = 2'd1,
    ADR_SENSE = 2'd2,
    ADR_VEC   = 2'd3
  } vic_addr_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    // idle level of an active-low line is 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int unsigned N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_n_i,
  input  logic [N-1:0] edge_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q, pend_q, fall;

  assign fall = edge_en_i & prev_q & ~req_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= req_n_i;
      for (int i = 0; i < N; i++) begin
        if (edge_en_i[i]) pend_q[i] <= fall[i] | (pend_q[i] & ~clr_i[i]);
        else              pend_q[i] <= ~req_n_i[i];
      end
    end
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r4_level_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(edge_en_i[i]) |-> pend_q[i] == !$past(req_n_i[i]));
    a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(edge_en_i[i] && clr_i[i] && !fall[i]) |-> !pend_q[i]);
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(edge_en_i[i] && !clr_i[i] && pend_q[i]) |-> pend_q[i]);
    a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(fall[i]) |-> pend_q[i]);
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N        = 15,
  parameter int unsigned VEC_W    = 6,
  parameter int unsigned IDLE_VEC = 15
) (
  input  logic [N-1:0]     active_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             any_o
);
  always_comb begin
    vec_o = VEC_W'(IDLE_VEC);
    // scan downward so the lowest index is assigned last
    for (int i = N - 1; i >= 0; i--) begin
      if (active_i[i]) vec_o = VEC_W'(i);
    end
    any_o = |active_i;
  end
endmodule

// File: rtl/sense_vic.sv
module sense_vic #(
  parameter int unsigned NUM_SRC  = 15,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned VEC_W    = 6,
  parameter int unsigned IDLE_VEC = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               irq_o
);
  import vic_pkg::*;

  localparam int unsigned TOP = REG_W - 1;

  logic [NUM_SRC-1:0] req_sync_n, pend, mask_q, sense_q, clr, active, win;
  logic [REG_W-1:0]   pend_w, mask_w, sense_w, vec_w;
  logic [VEC_W-1:0]   vec;
  logic               any, irq_q;
  vic_addr_e          adr;

  assign adr = vic_addr_e'(addr_i);

  vic_sync #(.W(NUM_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_ni), .q_o(req_sync_n)
  );

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign clr[n] = wr_en_i && (adr == ADR_PEND) && wr_data_i[TOP-n];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mask_q[n] <= 1'b0;
      else if (wr_en_i && adr == ADR_MASK)     mask_q[n] <= wr_data_i[TOP-n];
    end

    if (n % 2 == 0) begin : g_even
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           sense_q[n] <= 1'b0;
        else if (wr_en_i && adr == ADR_SENSE)  sense_q[n] <= wr_data_i[TOP-n];
      end
    end else begin : g_odd
      assign sense_q[n] = 1'b0;  // internal sources are level only
    end

    assign pend_w[TOP-n]  = pend[n];
    assign mask_w[TOP-n]  = mask_q[n];
    assign sense_w[TOP-n] = sense_q[n];
    assign win[n]         = any && (vec == VEC_W'(n));
  end

  assign pend_w[TOP-NUM_SRC:0]  = '0;
  assign mask_w[TOP-NUM_SRC:0]  = '0;
  assign sense_w[TOP-NUM_SRC:0] = '0;

  vic_pend #(.N(NUM_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_n_i(req_sync_n),
    .edge_en_i(sense_q), .clr_i(clr), .pend_o(pend)
  );

  assign active = pend & mask_q;

  vic_prio #(.N(NUM_SRC), .VEC_W(VEC_W), .IDLE_VEC(IDLE_VEC)) u_prio (
    .active_i(active), .vec_o(vec), .any_o(any)
  );

  assign vec_w = {vec, {(REG_W-VEC_W){1'b0}}};

  always_comb begin
    unique case (adr)
      ADR_PEND:  rd_data_o = pend_w;
      ADR_MASK:  rd_data_o = mask_w;
      ADR_SENSE: rd_data_o = sense_w;
      default:   rd_data_o = vec_w;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any;
  end
  assign irq_o = irq_q;

  a_r10_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend & mask_q)));
  a_r8_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|active) |-> ((|(win & active)) && ((active & (win - 1'b1)) == '0)));
  a_r9_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|active) |-> vec == VEC_W'(IDLE_VEC));
  a_r3_masked_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win & ~mask_q) == '0);
endmodule

// File: tb/sense_vic_tb.sv
module sense_vic_tb_top;
  localparam int NS = 15;
  localparam logic [31:0] IDLE = 32'h3C00_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NS-1:0] src_ni = '1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sense_vic dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .src_ni(src_ni), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] b(int n);
    return 32'h1 << (31 - n);
  endfunction

  function automatic logic [31:0] v(int n);
    return 32'(n) << 26;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R2 pend", d, 0);
    rd(1, d); chk("R2 mask", d, 0);
    rd(2, d); chk("R2 sense", d, 0);
    rd(3, d); chk("R2 vec", d, IDLE);
    chk("R2 irq", 32'(irq), 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R1 mask map", d, 32'hFFFE_0000);
    wr(1, b(0) | b(7));
    rd(1, d); chk("R1 mask bits", d, 32'h8100_0000);
    wr(1, 0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(1, b(1));
    src_ni[1] = 1'b0; cyc(5);
    rd(0, d); chk("R4 level pend", d, b(1));
    chk("R10 irq on", 32'(irq), 1);
    rd(3, d); chk("R9 vec 1", d, v(1));
    wr(0, b(1)); cyc(1);
    rd(0, d); chk("R4 w1c no effect", d, b(1));
    src_ni[1] = 1'b1; cyc(5);
    rd(0, d); chk("R4 level release", d, 0);
    chk("R10 irq off", 32'(irq), 0);
    wr(1, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    src_ni[3] = 1'b0; cyc(5);
    rd(0, d); chk("R3 pend visible", d, b(3));
    chk("R3 irq blocked", 32'(irq), 0);
    rd(3, d); chk("R3 vec blocked", d, IDLE);
    wr(1, b(3)); cyc(2);
    chk("R3 irq enabled", 32'(irq), 1);
    rd(3, d); chk("R3 vec enabled", d, v(3));
    src_ni[3] = 1'b1; wr(1, 0); cyc(5);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(2, b(2)); wr(1, b(2));
    src_ni[2] = 1'b0; cyc(5);
    src_ni[2] = 1'b1; cyc(5);
    rd(0, d); chk("R5 edge latched", d, b(2));
    chk("R5 irq", 32'(irq), 1);
    wr(0, 32'h0); cyc(1);
    rd(0, d); chk("R5 write0 keeps", d, b(2));
    wr(0, b(2)); cyc(2);
    rd(0, d); chk("R5 w1c clears", d, 0);
    chk("R5 irq drop", 32'(irq), 0);
    wr(2, 0); wr(1, 0);
  endtask

  task automatic t_odd_sense;
    logic [31:0] d, exp;
    exp = 0;
    for (int n = 0; n < NS; n += 2) exp |= b(n);
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R6 odd sense reads 0", d, exp);
    src_ni[5] = 1'b0; cyc(5);
    src_ni[5] = 1'b1; cyc(5);
    rd(0, d); chk("R6 odd stays level", d, 0);
    wr(2, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(2, b(4)); wr(1, b(4));
    src_ni[4] = 1'b0; cyc(5);
    src_ni[4] = 1'b1; cyc(5);
    @(negedge clk); src_ni[4] = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 2'd0; wdata = b(4); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(0, d); chk("R7 edge beats clear", d, b(4));
    src_ni[4] = 1'b1; cyc(5);
    wr(0, b(4)); cyc(1);
    rd(0, d); chk("R7 later clear", d, 0);
    wr(2, 0); wr(1, 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF);
    src_ni[6] = 1'b0; src_ni[9] = 1'b0; src_ni[12] = 1'b0; cyc(5);
    rd(3, d); chk("R8 lowest 6", d, v(6));
    wr(1, 32'hFFFF_FFFF & ~b(6));
    rd(3, d); chk("R8 next 9", d, v(9));
    src_ni[9] = 1'b1; cyc(5);
    rd(3, d); chk("R8 then 12", d, v(12));
    src_ni[6] = 1'b1; src_ni[12] = 1'b1; cyc(5);
    rd(3, d); chk("R9 idle code", d, IDLE);
    src_ni[14] = 1'b0; cyc(5);
    rd(3, d); chk("R9 vec 14", d, v(14));
    src_ni[14] = 1'b1; cyc(5);
    wr(1, 0);
  endtask

  task automatic t_vec_ro;
    logic [31:0] d;
    wr(1, b(8));
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R11 vec unchanged", d, IDLE);
    rd(1, d); chk("R11 mask unchanged", d, b(8));
    rd(2, d); chk("R11 sense unchanged", d, 0);
    rd(0, d); chk("R11 pend unchanged", d, 0);
    wr(1, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset;
    t_map;
    t_level;
    t_mask;
    t_edge;
    t_odd_sense;
    t_collide;
    t_prio;
    t_vec_ro;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule